// File: doc/BRIEF.md
# Parallel Product-Term Borrowing Chain

This block forms the OR sums for one group of sixteen logic cells. Each cell brings five product terms. A cell can keep those terms for its own sum. It can also hand them up to the cell above it as one set of five. A cell that keeps its terms can add up to three borrowed sets to its OR gate. The sets come from the cells directly beneath it, nearest first, so at most twenty terms reach one OR. The sixteen cells form two separate chains: cells 0–7 and cells 8–15. No set ever passes between the two chains.

For each cell the block also reports how many borrowed sets it actually used. Each set adds one unit of delay, so this count works as a delay estimate. When a configuration asks for terms it cannot have, the block raises a per-cell error flag and leaves the missing terms out. The results pass through one register stage.

Top module: `xp_chain_top`

## Requirements
- R1: A cell that keeps its own terms (lend bit 0, or the top cell of a chain) includes the OR of its five terms, `pterm_i[5c+4:5c]`, in `sum_o[c]`.
- R2: A lending cell (lend bit `lend_i[c]` = 1, not the top cell of a chain) drives `sum_o[c]` = 0 and `sets_o[c]` = 0.
- R3: A keeping cell with borrow count k = `borrow_i[2c+1:2c]` (0..3) takes the sets of cells c-1, c-2, … c-k, in that order. Its sum is the OR of its own terms and every set it takes. `sets_o[2c+1:2c]` gives the number of sets taken.
- R4: Cells 0–7 and cells 8–15 are separate chains. A set never crosses between them, even when the cell below the boundary has its lend bit set.
- R5: A bottom cell (0 or 8) that asks to borrow takes nothing. It reports `sets_o` = 0 and raises `err_o[c]`.
- R6: The lend bit of a top cell (7 or 15) is ignored. That cell keeps its terms and can still borrow.
- R7: When a requested donor is not lending, that set and every set below it are ignored. The cell's `err_o` is raised, and `sets_o` counts only the sets below c taken before the gap.
- R8: A lending cell with a nonzero borrow count raises `err_o[c]`, and its request is ignored.
- R9: All outputs are zero while `rst_n` is low. Otherwise they reflect the inputs sampled at the previous rising clock edge.
- R10: The terms of a lending cell that no cell claims reach no output. Unused term slots are forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pterm_i | input | 80 | Five product terms per cell; cell c at bits 5c+4..5c |
| lend_i | input | 16 | Per-cell lend bit; 1 hands the cell's five terms upward |
| borrow_i | input | 32 | Per-cell borrow count 0..3; cell c at bits 2c+1..2c |
| sum_o | output | 16 | Registered OR sum per cell |
| sets_o | output | 32 | Registered count of borrowed sets per cell; cell c at bits 2c+1..2c |
| err_o | output | 16 | Registered per-cell configuration error flag |

## Verification
Two things can happen in the same cycle. A cell can be lending, with its sum forced to zero, while also filing its own borrow request, which is the conflict flagged as an error. Likewise, a cell can borrow through a chain boundary at the very moment the cell below that boundary sets its ignored lend bit. Table rows that set every lend and borrow bit at once, followed by directed cases, provoke both pairings. A reference model built from the requirements judges the sum, count and error flag of every cell in those cycles.

// File: rtl/xp_pkg.sv
package xp_pkg;

    localparam int XP_MAXSETS = 3;
    localparam int XP_SETW    = $clog2(XP_MAXSETS + 1);

    typedef struct packed {
        logic               sum;
        logic [XP_SETW-1:0] sets;
        logic               err;
    } xp_cell_res_t;

endpackage

// File: rtl/xp_set_gate.sv
module xp_set_gate #(
    parameter int PTERM = 5
) (
    input  logic [PTERM-1:0] terms,
    input  logic             en,
    output logic             hit
);
    logic [PTERM-1:0] masked;

    always_comb begin
        masked = en ? terms : '0;
        hit    = |masked;
    end
endmodule

// File: rtl/xp_cell.sv
module xp_cell
    import xp_pkg::*;
#(
    parameter int PTERM     = 5,
    parameter int CHAIN     = 8,
    parameter int CHAIN_POS = 0
) (
    input  logic [PTERM-1:0]            own_terms,
    input  logic                        lend_self,
    input  logic [XP_SETW-1:0]          borrow_req,
    input  logic [XP_MAXSETS*PTERM-1:0] donor_terms,
    input  logic [XP_MAXSETS-1:0]       donor_lend,
    output xp_cell_res_t                res
);
    localparam bit IS_TOP = (CHAIN_POS == CHAIN - 1);

    logic                  lends;
    logic [XP_MAXSETS-1:0] take;
    logic [XP_MAXSETS-1:0] donor_hit;
    logic                  own_hit;
    logic [XP_SETW-1:0]    nsets;

    always_comb begin
        logic reach;
        lends = lend_self && !IS_TOP;
        reach = !lends;
        nsets = '0;
        for (int j = 0; j < XP_MAXSETS; j++) begin
            reach   = reach && (int'(borrow_req) > j) && (CHAIN_POS > j) && donor_lend[j];
            take[j] = reach;
            if (reach) nsets = nsets + XP_SETW'(1);
        end
    end

    xp_set_gate #(.PTERM(PTERM)) u_own (
        .terms(own_terms), .en(!lends), .hit(own_hit)
    );

    for (genvar j = 0; j < XP_MAXSETS; j++) begin : g_donor
        xp_set_gate #(.PTERM(PTERM)) u_set (
            .terms(donor_terms[j*PTERM +: PTERM]), .en(take[j]), .hit(donor_hit[j])
        );
    end

    always_comb begin
        res.sum  = own_hit || (|donor_hit);
        res.sets = nsets;
        res.err  = lends ? (borrow_req != '0) : (borrow_req != nsets);
    end
endmodule

// File: rtl/xp_chain_top.sv
module xp_chain_top
    import xp_pkg::*;
#(
    parameter int NCELL = 16,
    parameter int CHAIN = 8,
    parameter int PTERM = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCELL*PTERM-1:0]   pterm_i,
    input  logic [NCELL-1:0]         lend_i,
    input  logic [NCELL*XP_SETW-1:0] borrow_i,
    output logic [NCELL-1:0]         sum_o,
    output logic [NCELL*XP_SETW-1:0] sets_o,
    output logic [NCELL-1:0]         err_o
);
    localparam int DW = XP_MAXSETS * PTERM;

    xp_cell_res_t [NCELL-1:0] res;
    xp_cell_res_t [NCELL-1:0] state_d;
    xp_cell_res_t [NCELL-1:0] state_q;

    logic [DW-1:0]         dterm [NCELL];
    logic [XP_MAXSETS-1:0] dlend [NCELL];

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        for (genvar j = 0; j < XP_MAXSETS; j++) begin : g_wire
            if (c - j - 1 >= 0) begin : g_real
                assign dterm[c][j*PTERM +: PTERM] = pterm_i[(c-j-1)*PTERM +: PTERM];
                assign dlend[c][j]                = lend_i[c-j-1];
            end else begin : g_none
                assign dterm[c][j*PTERM +: PTERM] = '0;
                assign dlend[c][j]                = 1'b0;
            end
        end

        xp_cell #(.PTERM(PTERM), .CHAIN(CHAIN), .CHAIN_POS(c % CHAIN)) u_cell (
            .own_terms  (pterm_i[c*PTERM +: PTERM]),
            .lend_self  (lend_i[c]),
            .borrow_req (borrow_i[c*XP_SETW +: XP_SETW]),
            .donor_terms(dterm[c]),
            .donor_lend (dlend[c]),
            .res        (res[c])
        );
    end

    always_comb begin
        state_d = res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        for (int c = 0; c < NCELL; c++) begin
            sum_o[c]                     = state_q[c].sum;
            sets_o[c*XP_SETW +: XP_SETW] = state_q[c].sets;
            err_o[c]                     = state_q[c].err;
        end
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_chk
        AST_IDLE_NO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (borrow_i[c*XP_SETW +: XP_SETW] == '0) |=> (sets_o[c*XP_SETW +: XP_SETW] == '0)); // R3
        if (c % CHAIN != CHAIN - 1) begin : g_lend
            AST_LEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                lend_i[c] |=> (!sum_o[c] && sets_o[c*XP_SETW +: XP_SETW] == '0)); // R2
            AST_OWN_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
                (!lend_i[c] && |pterm_i[c*PTERM +: PTERM]) |=> sum_o[c]); // R1
        end else begin : g_top
            AST_TOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (|pterm_i[c*PTERM +: PTERM]) |=> sum_o[c]); // R6
        end
        if (c % CHAIN == 0) begin : g_bottom
            AST_BOTTOM_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
                (borrow_i[c*XP_SETW +: XP_SETW] != '0)
                |=> (err_o[c] && sets_o[c*XP_SETW +: XP_SETW] == '0)); // R5
        end
    end
endmodule

// File: tb/sim_xp_chain_top.sv
module sim_xp_chain_top;
    localparam int N = 16;
    localparam int NV = 6;
    localparam logic [127:0] VEC [NV] = '{
        {80'h0_0000_0000_0000_0001_F, 16'h0000, 32'h0000_0000},
        {80'h8_4210_8421_0842_1084_2, 16'h0707, 32'h00C0_00C0},
        {80'h1_2345_6789_ABCD_EF01_2, 16'hAAAA, 32'h5555_5555},
        {80'hF_0F0F_0F0F_0F0F_0F0F_0, 16'h5555, 32'hAAAA_AAAA},
        {80'h0_0001_0000_0100_0010_0, 16'hFFFF, 32'hFFFF_FFFF},
        {80'hC_0300_C030_0C03_00C0_3, 16'h3C3C, 32'h1234_5678}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [79:0]   pterm_i = '0;
    logic [15:0]   lend_i = '0;
    logic [31:0]   borrow_i = '0;
    logic [15:0]   sum_o;
    logic [31:0]   sets_o;
    logic [15:0]   err_o;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    xp_chain_top u0 (.clk(clk), .rst_n(rst_n), .pterm_i(pterm_i), .lend_i(lend_i),
                     .borrow_i(borrow_i), .sum_o(sum_o), .sets_o(sets_o), .err_o(err_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic [79:0] t, input logic [15:0] l, input logic [31:0] b,
                         output logic [15:0] s, output logic [31:0] k, output logic [15:0] e);
        s = '0; k = '0; e = '0;
        for (int c = 0; c < N; c++) begin
            int pos = c % 8;
            int want = int'(b[2*c +: 2]);
            if (l[c] && pos != 7) begin
                e[c] = (want != 0);
            end else begin
                int got = 0;
                bit gap = 0;
                s[c] = |t[5*c +: 5];
                for (int j = 1; j <= want; j++) begin
                    if (!gap && j <= pos && l[c-j]) begin
                        s[c] = s[c] | (|t[5*(c-j) +: 5]);
                        got++;
                    end else gap = 1;
                end
                k[2*c +: 2] = 2'(got);
                e[c] = gap;
            end
        end
    endtask

    task automatic apply(input logic [79:0] t, input logic [15:0] l, input logic [31:0] b);
        @(negedge clk);
        pterm_i = t; lend_i = l; borrow_i = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] es, ee;
        logic [31:0] ek;
        // R9: reset holds outputs low even with busy inputs
        pterm_i = '1; lend_i = 16'h00FF; borrow_i = '1;
        repeat (3) @(negedge clk);
        check("R9 reset sum", {16'h0, sum_o}, 32'h0);
        check("R9 reset sets", sets_o, 32'h0);
        check("R9 reset err", {16'h0, err_o}, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][127:48], VEC[v][47:32], VEC[v][31:0]);
            model(VEC[v][127:48], VEC[v][47:32], VEC[v][31:0], es, ek, ee);
            check("R1 R2 R3 R8 row sum", {16'h0, sum_o}, {16'h0, es});
            check("R3 R4 R7 row sets", sets_o, ek);
            check("R5 R7 R8 row err", {16'h0, err_o}, {16'h0, ee});
        end

        // R3: cell 3 takes three sets; only cell 0 has a term
        apply(80'h1, 16'h0007, 32'h0000_00C0);
        check("R3 sum3", {31'h0, sum_o[3]}, 32'h1);
        check("R3 sets3", {30'h0, sets_o[7:6]}, 32'h3);
        check("R3 err3", {31'h0, err_o[3]}, 32'h0);

        // R4 R5 R6: cell 8 borrows across the boundary; cell 7 lend bit ignored
        apply(80'h1 << 35, 16'h0080, 32'h0001_0000);
        check("R4 sum8", {31'h0, sum_o[8]}, 32'h0);
        check("R5 sets8", {30'h0, sets_o[17:16]}, 32'h0);
        check("R5 err8", {31'h0, err_o[8]}, 32'h1);
        check("R6 sum7", {31'h0, sum_o[7]}, 32'h1);

        // R7: cell 5 asks 3, cell 4 lends, cell 3 does not, cell 2 lends with terms
        apply(80'h1 << 10, 16'h0014, 32'h0000_0C00);
        check("R7 sets5", {30'h0, sets_o[11:10]}, 32'h1);
        check("R7 err5", {31'h0, err_o[5]}, 32'h1);
        check("R7 sum5", {31'h0, sum_o[5]}, 32'h0);

        // R8: cell 2 lends and also asks to borrow from lending cell 1
        apply(80'h1F << 5 | 80'h1F << 10, 16'h0006, 32'h0000_0010);
        check("R8 err2", {31'h0, err_o[2]}, 32'h1);
        check("R8 sum2", {31'h0, sum_o[2]}, 32'h0);
        check("R8 sets2", {30'h0, sets_o[5:4]}, 32'h0);

        // R10: unclaimed lent terms of cell 10 reach no output
        apply(80'h1F << 50, 16'h0400, 32'h0);
        check("R10 sums", {16'h0, sum_o}, 32'h0);

        // R2 R1: cell 0 lends, cell 1 keeps without borrowing
        apply(80'h3, 16'h0001, 32'h0);
        check("R2 sum0", {31'h0, sum_o[0]}, 32'h0);
        check("R1 sum1", {31'h0, sum_o[1]}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule